// File: doc/BRIEF.md
# Three-Channel Comparator Event Timer

The block keeps a 64-bit main counter that advances once per clock while a global enable is set, and a small set of timer channels (three by default) that compare against it. Each channel runs one-shot or periodic, in 64-bit or 32-bit mode. When a channel matches, it sends a single-cycle pulse on one of the interrupt lines and sets its bit in a status word. A periodic channel keeps its period apart from its running comparator. Each match moves the comparator forward by exactly one period from its old value, so the pulse train never drifts from the counter.

Software reaches the block through a single-cycle register port of 64-bit words. A write takes effect at the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`. The port has no data stream, so it carries no valid/ready handshake: every write is accepted and every read is answered in the same cycle. The word map is:

| Word | Contents |
|------|----------|
| 0 | global config |
| 1 | status |
| 2 | main counter |
| 4+2n | config of channel n |
| 5+2n | comparator of channel n |

Any other word reads zero.

Top module: `evt_timer`

## Requirements
- R1: The counter (word 2) advances by one per cycle only while the global enable (word 0, bit 0) is set. While the enable is clear it holds its value, and counting resumes from the held value.
- R2: A write to word 2 loads the counter and re-arms every enabled channel. A one-shot channel that has already fired fires again when the counter next equals its comparator. Setting the global enable also re-arms every enabled channel.
- R3: A comparator write to a periodic channel (config bit 3) with SETVAL (config bit 6) clear stores the value as both the next match point and the period. The period loses its top bit: bit 31 in 32-bit mode, bit 63 otherwise.
- R4: A comparator write with SETVAL set changes only the match point and leaves the period unchanged. SETVAL then reads back as 0.
- R5: On each match a periodic channel moves its comparator forward by its period from the old comparator value. It gives exactly one pulse per elapsed period, and a comparator read returns the next match point.
- R6: In 32-bit mode (config bit 8), comparator values are truncated to 32 bits and the match uses only the low 32 bits of the counter. Switching from 64-bit to 32-bit mode while enabled truncates the comparator and the period, and re-arms the channel.
- R7: A one-shot channel pulses once, in the cycle after the counter equals its comparator, so the counter reads comparator+1 during the pulse. It then stays quiet until it is re-armed by one of these: a comparator write, a counter write, a global-enable rise, a channel-enable rise, or a mode change.
- R8: A periodic channel whose period is zero behaves as a one-shot channel.
- R9: Config bits 13:9 select the interrupt line. A route value of 24 or more drives no line. When the legacy bit (word 0, bit 1) is set, channel 0 pulses line 0 and channel 1 pulses line 8, whatever their route fields hold.
- R10: Status bit n (word 1) is set when channel n matches. Writing 1 to a bit clears it and writing 0 leaves it alone. A match in the same cycle as a clear wins.
- R11: After reset:
  - the counter, global config and status read 0;
  - every comparator reads all ones;
  - every channel config reads 64'h00FF_FFFF_0000_0030: periodic-capable bit 4 and 64-bit-capable bit 5 set, route-capability bits 55:32 all ones.
- R12: The channel enable (config bit 2) affects only its own channel. A disabled channel gives no pulses while the others continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Word index for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| irq | output | 24 | Interrupt lines, one-cycle pulse per match |

## Verification
The embedded assertions check these rules on every cycle:
- the counter holds while disabled and steps by one while enabled;
- SETVAL clears after a comparator write;
- a periodic comparator steps by exactly one period per match;
- a one-shot channel falls silent after it fires;
- the upper comparator half stays zero in 32-bit mode;
- legacy routing lands on lines 0 and 8;
- every match sets its status bit.

Other behaviour shows only in the bench's scenarios:
- re-arming after a counter rewrite;
- period masking at bit 31 and bit 63;
- the one-pulse limit when the period is zero;
- the exact counter value during a pulse;
- per-channel disable;
- the write-one-to-clear status;
- pulse counts over random periods and windows.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DW      = 64;
  localparam int RTW     = 5;
  localparam int A_GCFG  = 0;
  localparam int A_STAT  = 1;
  localparam int A_CNT   = 2;
  localparam int A_CHB   = 4;
  localparam int CB_EN   = 2;
  localparam int CB_PER  = 3;
  localparam int CB_PCAP = 4;
  localparam int CB_SCAP = 5;
  localparam int CB_SV   = 6;
  localparam int CB_M32  = 8;
  localparam int CB_RT   = 9;
  localparam int CB_RCAP = 32;

  typedef struct packed {
    logic           en;
    logic           per;
    logic           m32;
    logic           sv;
    logic [RTW-1:0] route;
  } ch_cfg_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)   value <= '0;
    else if (ld)  value <= ld_val;
    else if (run) value <= value + W'(1);
  end

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> (value == $past(value)));
  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld) |=> (value == $past(value) + W'(1)));
endmodule

// File: rtl/evt_channel.sv
module evt_channel import evt_timer_pkg::*; #(
  parameter int NIRQ = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           glb_en,
  input  logic [DW-1:0]  cnt,
  input  logic           rearm,
  input  logic           cfg_we,
  input  logic           cmp_we,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  cfg_rd,
  output logic [DW-1:0]  cmp_rd,
  output logic           hit,
  output logic [RTW-1:0] route
);
  localparam logic [DW-1:0] MASK64 = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MASK32 = {{(DW-31){1'b0}}, {31{1'b1}}};

  ch_cfg_t       cfg;
  logic [DW-1:0] cmp, period, wv, sum, nxt;
  logic          armed, eq;

  assign wv  = cfg.m32 ? {32'b0, wdata[31:0]} : wdata;
  assign sum = cmp + period;
  assign nxt = cfg.m32 ? {32'b0, sum[31:0]} : sum;
  assign eq  = cfg.m32 ? (cnt[31:0] == cmp[31:0]) : (cnt == cmp);
  assign hit = glb_en & cfg.en & armed & eq;
  assign route  = cfg.route;
  assign cmp_rd = cmp;

  always_comb begin
    cfg_rd = '0;
    cfg_rd[CB_EN]   = cfg.en;
    cfg_rd[CB_PER]  = cfg.per;
    cfg_rd[CB_PCAP] = 1'b1;
    cfg_rd[CB_SCAP] = 1'b1;
    cfg_rd[CB_SV]   = cfg.sv;
    cfg_rd[CB_M32]  = cfg.m32;
    cfg_rd[CB_RT +: RTW]    = cfg.route;
    cfg_rd[CB_RCAP +: NIRQ] = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      cmp    <= '1;
      period <= '0;
      armed  <= 1'b0;
    end else if (cmp_we) begin
      cmp   <= wv;
      armed <= 1'b1;
      if (cfg.sv)       cfg.sv <= 1'b0;
      else if (cfg.per) period <= wv & (cfg.m32 ? MASK32 : MASK64);
    end else if (cfg_we) begin
      cfg.en    <= wdata[CB_EN];
      cfg.per   <= wdata[CB_PER];
      cfg.m32   <= wdata[CB_M32];
      cfg.sv    <= wdata[CB_SV];
      cfg.route <= wdata[CB_RT +: RTW];
      if (wdata[CB_M32] && !cfg.m32) begin
        cmp    <= {32'b0, cmp[31:0]};
        period <= {32'b0, period[31:0]};
      end
      if (!wdata[CB_EN])
        armed <= 1'b0;
      else if (!cfg.en || (wdata[CB_PER] != cfg.per) || (wdata[CB_M32] && !cfg.m32))
        armed <= 1'b1;
    end else if (rearm) begin
      armed <= cfg.en;
    end else if (hit) begin
      if (cfg.per && (period != '0)) cmp   <= nxt;
      else                           armed <= 1'b0;
    end
  end

  // R4
  sv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> !cfg_rd[CB_SV]);
  // R5
  per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg.per && !cfg.m32 && (period != '0) && !cmp_we && !cfg_we && !rearm)
      |=> (cmp_rd == $past(cmp_rd) + $past(period)));
  // R7
  oneshot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cfg.per && !cmp_we && !cfg_we && !rearm) |=> !hit);
  // R6
  m32_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd[CB_M32] |-> (cmp_rd[63:32] == 32'b0));
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route import evt_timer_pkg::*; #(
  parameter int NCH  = 3,
  parameter int NIRQ = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      legacy,
  input  logic [NCH-1:0]            hit,
  input  logic [NCH-1:0][RTW-1:0]   route,
  output logic [NIRQ-1:0]           irq
);
  logic [NIRQ-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      logic [RTW-1:0] line;
      if (legacy && ch == 0)      line = RTW'(0);
      else if (legacy && ch == 1) line = RTW'(8);
      else                        line = route[ch];
      if (hit[ch] && (int'(line) < NIRQ)) nxt[line] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= '0;
    else        irq <= nxt;
  end

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> (irq == '0));
  // R9
  legacy0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy && hit[0]) |=> irq[0]);
  generate
    if (NCH > 1 && NIRQ > 8) begin : g_leg1
      // R9
      legacy1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy && hit[1]) |=> irq[8]);
    end
  endgenerate
endmodule

// File: rtl/evt_timer.sv
module evt_timer import evt_timer_pkg::*; #(
  parameter int NCH  = 3,
  parameter int NIRQ = 24,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [NIRQ-1:0] irq
);
  logic                    glb_en, legacy, glb_rise, cnt_we, rearm, stat_we;
  logic [DW-1:0]           cnt;
  logic [NCH-1:0]          status, hit, cfg_we, cmp_we;
  logic [NCH-1:0][RTW-1:0] ch_route;
  logic [DW-1:0]           ch_cfg [NCH];
  logic [DW-1:0]           ch_cmp [NCH];

  assign cnt_we   = reg_we && (reg_addr == AW'(A_CNT));
  assign stat_we  = reg_we && (reg_addr == AW'(A_STAT));
  assign glb_rise = reg_we && (reg_addr == AW'(A_GCFG)) && reg_wdata[0] && !glb_en;
  assign rearm    = cnt_we | glb_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      legacy <= 1'b0;
      status <= '0;
    end else begin
      if (reg_we && (reg_addr == AW'(A_GCFG))) begin
        glb_en <= reg_wdata[0];
        legacy <= reg_wdata[1];
      end
      status <= (status & ~(stat_we ? reg_wdata[NCH-1:0] : '0)) | hit;
    end
  end

  evt_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(glb_en), .ld(cnt_we),
    .ld_val(reg_wdata), .value(cnt)
  );

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      assign cfg_we[n] = reg_we && (reg_addr == AW'(A_CHB + 2*n));
      assign cmp_we[n] = reg_we && (reg_addr == AW'(A_CHB + 2*n + 1));
      evt_channel #(.NIRQ(NIRQ)) u_ch (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cnt(cnt), .rearm(rearm),
        .cfg_we(cfg_we[n]), .cmp_we(cmp_we[n]), .wdata(reg_wdata),
        .cfg_rd(ch_cfg[n]), .cmp_rd(ch_cmp[n]), .hit(hit[n]), .route(ch_route[n])
      );
    end
  endgenerate

  evt_irq_route #(.NCH(NCH), .NIRQ(NIRQ)) u_rt (
    .clk(clk), .rst_n(rst_n), .legacy(legacy), .hit(hit), .route(ch_route), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_GCFG))      reg_rdata = {{(DW-2){1'b0}}, legacy, glb_en};
    else if (reg_addr == AW'(A_STAT)) reg_rdata = {{(DW-NCH){1'b0}}, status};
    else if (reg_addr == AW'(A_CNT))  reg_rdata = cnt;
    for (int n = 0; n < NCH; n++) begin
      if (reg_addr == AW'(A_CHB + 2*n))     reg_rdata = ch_cfg[n];
      if (reg_addr == AW'(A_CHB + 2*n + 1)) reg_rdata = ch_cmp[n];
    end
  end

  // R10
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status & $past(hit)) == $past(hit)));
  // R1
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !cnt_we) |=> $stable(cnt));
endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [23:0] irq;

  int checks = 0, failures = 0, pcnt [24];
  bit done = 0;

  localparam logic [63:0] EN = 64'h4, PER = 64'h8, SV = 64'h40, M32 = 64'h100;

  evt_timer u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
                .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #10 clk = ~clk;

  initial for (int i = 0; i < 24; i++) pcnt[i] = 0;
  always @(negedge clk) for (int i = 0; i < 24; i++) if (irq[i]) pcnt[i]++;

  function automatic logic [63:0] rt(input int r);
    return 64'(r) << 9;
  endfunction
  function automatic int exp_pulses(input logic [63:0] f, input int p);
    return int'((f - 64'd1) / 64'(p));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input int a, output logic [63:0] d);
    @(negedge clk); reg_addr = 4'(a); #1 d = reg_rdata;
  endtask
  task automatic wait_pulse(input int line, input int maxc, output bit found, output logic [63:0] cv);
    found = 0; cv = '0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (irq[line]) begin reg_addr = 4'd2; #1 cv = reg_rdata; found = 1; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, cv;
    bit f;
    int b0, b1, b2, b3, s;
    s = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 irq", 64'(irq), 64'h0);
    rd(0, d); chk("R11 gcfg", d, 64'h0);
    rd(1, d); chk("R11 status", d, 64'h0);
    rd(2, d); chk("R11 counter", d, 64'h0);
    for (int n = 0; n < 3; n++) begin
      rd(4 + 2*n, d); chk("R11 chcfg", d, 64'h00FF_FFFF_0000_0030);
      rd(5 + 2*n, d); chk("R11 cmp", d, '1);
    end
    // R1 freeze and resume
    wr(2, 64'd100);
    repeat (10) @(negedge clk);
    rd(2, d); chk("R1 frozen", d, 64'd100);
    wr(0, 64'h1);
    repeat (20) @(negedge clk);
    wr(0, 64'h0);
    repeat (5) @(negedge clk);
    rd(2, d); chk("R1 count", d, 64'd122);
    // R7 one-shot exact timing, R2 rearm by counter write
    wr(2, 64'd0);
    wr(4, EN | rt(4));
    wr(5, 64'd10);
    b0 = pcnt[4];
    wr(0, 64'h1);
    wait_pulse(4, 40, f, cv);
    chk("R7 fired", 64'(f), 64'd1);
    chk("R7 cnt at pulse", cv, 64'd11);
    repeat (5) @(negedge clk);
    wr(2, 64'd3);
    wait_pulse(4, 40, f, cv);
    chk("R2 refire", 64'(f), 64'd1);
    chk("R2 cnt at pulse", cv, 64'd11);
    repeat (30) @(negedge clk);
    chk("R7 no extra", 64'(pcnt[4] - b0), 64'd2);
    wr(0, 64'h0);
    // R10 status
    rd(1, d); chk("R10 set", d & 64'h1, 64'h1);
    wr(1, 64'h2);
    rd(1, d); chk("R10 zero keeps", d & 64'h1, 64'h1);
    wr(1, 64'h1);
    rd(1, d); chk("R10 clear", d & 64'h1, 64'h0);
    wr(4, 64'h0);
    // R3 R4 R5 setval and periodic stepping
    wr(2, 64'd0);
    wr(6, PER | EN | rt(3));
    wr(7, 64'd10);
    wr(6, PER | EN | SV | rt(3));
    rd(6, d); chk("R4 sv set", (d >> 6) & 1, 64'h1);
    wr(7, 64'd25);
    rd(6, d); chk("R4 sv clear", (d >> 6) & 1, 64'h0);
    wr(0, 64'h1);
    wait_pulse(3, 60, f, cv); chk("R4 first", cv, 64'd26);
    wait_pulse(3, 60, f, cv); chk("R5 step", cv, 64'd36);
    rd(7, d); chk("R5 readback", d, 64'd45);
    wr(0, 64'h0);
    // R8 period zero
    wr(2, 64'hFFFF_FFFF_FFFF_FFF8);
    wr(7, 64'd0);
    b0 = pcnt[3];
    wr(0, 64'h1);
    repeat (40) @(negedge clk);
    wr(0, 64'h0);
    chk("R8 single", 64'(pcnt[3] - b0), 64'd1);
    wr(6, 64'h0);
    // R3 mask bit 63
    wr(2, 64'h8000_0000_0000_0000);
    wr(8, PER | EN | rt(12));
    wr(9, 64'h8000_0000_0000_0004);
    wr(0, 64'h1);
    wait_pulse(12, 20, f, cv); chk("R3 64 first", cv, 64'h8000_0000_0000_0005);
    wait_pulse(12, 20, f, cv); chk("R3 64 period", cv, 64'h8000_0000_0000_0009);
    wr(0, 64'h0);
    // R3 R6 mask bit 31 in 32-bit mode
    wr(2, 64'h8000_0000);
    wr(8, PER | EN | M32 | rt(12));
    wr(9, 64'hFFFF_FFFF_8000_0006);
    rd(9, d); chk("R6 truncate", d, 64'h8000_0006);
    wr(0, 64'h1);
    wait_pulse(12, 20, f, cv); chk("R6 first", cv, 64'h8000_0007);
    wait_pulse(12, 20, f, cv); chk("R3 32 period", cv, 64'h8000_000D);
    wr(0, 64'h0);
    wr(8, 64'h0);
    // R6 low-32 match
    wr(2, 64'h3_0000_0008);
    wr(4, EN | M32 | rt(4));
    wr(5, 64'h10);
    wr(0, 64'h1);
    wait_pulse(4, 30, f, cv); chk("R6 low match", cv, 64'h3_0000_0011);
    wr(0, 64'h0);
    // R9 legacy routing
    wr(2, 64'd0);
    wr(4, EN | rt(5));  wr(5, 64'd6);
    wr(6, EN | rt(6));  wr(7, 64'd9);
    b0 = pcnt[0]; b1 = pcnt[5]; b2 = pcnt[8]; b3 = pcnt[6];
    wr(0, 64'h3);
    repeat (20) @(negedge clk);
    wr(0, 64'h0);
    chk("R9 line0", 64'(pcnt[0] - b0), 64'd1);
    chk("R9 not route5", 64'(pcnt[5] - b1), 64'd0);
    chk("R9 line8", 64'(pcnt[8] - b2), 64'd1);
    chk("R9 not route6", 64'(pcnt[6] - b3), 64'd0);
    // R12 per-channel disable
    wr(2, 64'd0);
    wr(4, PER | EN | rt(4)); wr(5, 64'd5);
    wr(6, PER | EN | rt(3)); wr(7, 64'd7);
    wr(0, 64'h1);
    repeat (30) @(negedge clk);
    wr(6, 64'h0);
    b0 = pcnt[4]; b1 = pcnt[3];
    repeat (30) @(negedge clk);
    wr(0, 64'h0);
    chk("R12 stopped", 64'(pcnt[3] - b1), 64'd0);
    chk("R12 other runs", 64'(pcnt[4] - b0 >= 5), 64'd1);
    wr(4, 64'h0);
    // R5 random periods and windows
    for (int k = 0; k < 6; k++) begin
      int p, w, ln;
      p  = $urandom_range(17, 3);
      w  = $urandom_range(200, 40);
      ln = $urandom_range(20, 10);
      wr(2, 64'd0);
      wr(8, PER | EN | rt(ln));
      wr(9, 64'(p));
      b0 = pcnt[ln];
      wr(0, 64'h1);
      repeat (w) @(negedge clk);
      wr(0, 64'h0);
      repeat (3) @(negedge clk);
      rd(2, cv);
      chk("R5 pulse count", 64'(pcnt[ln] - b0), 64'(exp_pulses(cv, p)));
      rd(9, d);
      chk("R5 next match", d, 64'((exp_pulses(cv, p) + 1) * p));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule